// File: doc/BRIEF.md
# Queued Indirect Flash Read Sequencer

This block moves software-requested runs of bytes from a serial flash into a local byte buffer. Software writes a flash start address and a byte count, then pulses a start control. Up to two such operations can wait in the block. The first one runs while the second waits. The second begins as soon as the last byte of the first has landed in the buffer.

Reads go out as bursts to a lower-level serial protocol engine. The handshake has three parts. The block raises a request carrying an address and a length. The engine grants it. The engine then returns exactly that many bytes, one per valid cycle. Each burst is sized so that it fits in the free space of the buffer. When the buffer is full, the block stops issuing bursts. Once a master pops bytes out, it starts a fresh burst at the first byte it has not yet read. The block keeps the buffer fill count, which software can read. It raises three sticky interrupt flags, all cleared by writing 1:
- a watermark flag,
- a completion flag,
- a rejection flag for starts that arrive while both queue slots are taken.

The protocol engine and the buffer storage sit outside the block.

Top module: `ixr_read_sequencer`

## Requirements
- R1: Out of reset, `busy_o`, `fill_level_o`, `eng_req_o` and all three interrupt flags are 0.
- R2: A start pulse is accepted when fewer than two operations are queued. A second accepted operation runs only after the first has delivered its final byte. Each operation's bytes enter the buffer in flash-address order from its own start address. Lengths are 1 or more.
- R3: A start pulse that arrives while two operations are already queued leaves the queue unchanged and sets `irq_reject_o` in the next cycle.
- R4: Each burst request has length = min(`MAX_BURST`, bytes still to fetch for the operation, buffer free space at the time it is planned). It is never zero. Its address and length hold steady until `eng_gnt_i` is seen. While the buffer is full, no request is raised.
- R5: The address of each burst equals the operation start address plus the number of bytes already received for that operation. A transfer cut short by buffer space therefore resumes at the next unread address.
- R6: `buf_push_o` mirrors an accepted engine byte in the same cycle. `fill_level_o` equals pushes minus pops. A pop at fill 0 has no effect, and fill never exceeds `DEPTH`.
- R7: With a nonzero watermark W, `irq_wmark_o` is set in the cycle after the fill level rises from at most W to above W. A watermark of 0 disables the flag.
- R8: With a nonzero watermark, `irq_wmark_o` is also set when the final byte of an operation is pushed, even if the fill never exceeded W.
- R9: `irq_done_o` is set in the cycle after an operation's final byte is pushed.
- R10: A cancel pulse empties both queue slots and withdraws any ungranted request. Bytes still due from a granted burst are taken from the engine and discarded without a push. `irq_done_o` is not raised for the cancelled work.
- R11: The flags are sticky. Bit 0 of `irq_clr_i` clears the watermark flag, bit 1 clears the completion flag and bit 2 clears the rejection flag. A set in the same cycle wins over a clear.
- R12: `busy_o` is 1 while any operation is queued or discarded bytes are still expected, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start_i | input | 1 | One-cycle start pulse for a new operation |
| sw_cancel_i | input | 1 | One-cycle cancel pulse |
| sw_addr_i | input | ADDR_W | Flash start address of the new operation |
| sw_len_i | input | LEN_W | Byte count of the new operation (1 or more) |
| sw_wmark_i | input | FILL_W | Fill watermark, 0 disables |
| irq_clr_i | input | 3 | Write-1 clears: [0] watermark, [1] done, [2] reject |
| busy_o | output | 1 | Operation queued or discard in progress |
| fill_level_o | output | FILL_W | Bytes currently held in the buffer |
| irq_wmark_o | output | 1 | Sticky watermark flag |
| irq_done_o | output | 1 | Sticky completion flag |
| irq_reject_o | output | 1 | Sticky rejection flag |
| eng_req_o | output | 1 | Burst request to the protocol engine |
| eng_addr_o | output | ADDR_W | Flash address of the requested burst |
| eng_len_o | output | BURST_W | Byte length of the requested burst |
| eng_gnt_i | input | 1 | Engine accepts the request this cycle |
| eng_vld_i | input | 1 | Engine returns one byte this cycle |
| eng_data_i | input | 8 | Returned byte |
| buf_push_o | output | 1 | Write one byte into the buffer |
| buf_data_o | output | 8 | Byte to write |
| buf_pop_i | input | 1 | A master removed one byte from the buffer |

## Verification
Every cycle, the embedded properties check the following:
- a request keeps its address and length until it is granted;
- bursts stay within `MAX_BURST`, within the free space and within the bytes left;
- the buffer never overflows, and a pop at zero fill changes nothing;
- a pending slot never exists without an active one;
- rejections, completions and cancels reach their flags or silence the request one cycle later.

Some behaviours need whole scenarios, which the bench drives:
- the byte order across a buffer-full stall;
- resumption at the first unread address;
- a queued second operation following the first;
- the watermark set by the final byte alone;
- discarding of in-flight bytes after a cancel.

The bench's behavioural model compares fill, busy and all three flags against the design on every clock.

// File: rtl/ixr_pkg.sv
package ixr_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_REQ   = 2'd1,
        SQ_DATA  = 2'd2,
        SQ_DRAIN = 2'd3
    } sq_state_e;

    localparam int unsigned IRQ_WMARK  = 0;
    localparam int unsigned IRQ_DONE   = 1;
    localparam int unsigned IRQ_REJECT = 2;
    localparam int unsigned IRQ_N      = 3;

    function automatic int unsigned min3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b < m) m = b;
        if (c < m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/ixr_op_queue.sv
module ixr_op_queue #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cancel_i,
    input  logic              retire_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              act_valid_o,
    output logic [ADDR_W-1:0] act_addr_o,
    output logic [LEN_W-1:0]  act_len_o,
    output logic              full_o,
    output logic              reject_o
);

    typedef struct packed {
        logic              act_v;
        logic [ADDR_W-1:0] act_a;
        logic [LEN_W-1:0]  act_l;
        logic              pnd_v;
        logic [ADDR_W-1:0] pnd_a;
        logic [LEN_W-1:0]  pnd_l;
    } slots_t;

    slots_t slot_d, slot_q;
    logic   accept;

    always_comb begin
        slot_d   = slot_q;
        full_o   = slot_q.act_v && slot_q.pnd_v;
        reject_o = start_i && !cancel_i && full_o;
        accept   = start_i && !cancel_i && !full_o;
        if (cancel_i) begin
            slot_d.act_v = 1'b0;
            slot_d.pnd_v = 1'b0;
        end else begin
            if (retire_i) begin
                slot_d.act_v = slot_q.pnd_v;
                slot_d.act_a = slot_q.pnd_a;
                slot_d.act_l = slot_q.pnd_l;
                slot_d.pnd_v = 1'b0;
            end
            if (accept) begin
                if (!slot_d.act_v) begin
                    slot_d.act_v = 1'b1;
                    slot_d.act_a = addr_i;
                    slot_d.act_l = len_i;
                end else begin
                    slot_d.pnd_v = 1'b1;
                    slot_d.pnd_a = addr_i;
                    slot_d.pnd_l = len_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign act_valid_o = slot_q.act_v;
    assign act_addr_o  = slot_q.act_a;
    assign act_len_o   = slot_q.act_l;

    // R2: a waiting slot is only ever behind a running one
    assert_pending_behind_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.pnd_v |-> slot_q.act_v);

    // R2: zero-length operations are outside the contract
    assert_nonzero_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (len_i != '0));

    // R3: a refused start leaves the waiting slot untouched
    assert_full_keeps_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && start_i && !cancel_i && !retire_i) |=>
            (slot_q.pnd_v && $stable(slot_q.pnd_a) && $stable(slot_q.pnd_l)));

endmodule

// File: rtl/ixr_fill_track.sv
module ixr_fill_track #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned FILL_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              final_i,
    input  logic [FILL_W-1:0] wmark_i,
    output logic [FILL_W-1:0] fill_o,
    output logic [FILL_W-1:0] free_o,
    output logic              wm_hit_o
);

    typedef struct packed {
        logic [FILL_W-1:0] level;
    } fill_t;

    fill_t fill_d, fill_q;
    logic  pop_eff;

    always_comb begin
        pop_eff      = pop_i && (fill_q.level != '0);
        fill_d       = fill_q;
        fill_d.level = fill_q.level + FILL_W'(push_i) - FILL_W'(pop_eff);
        wm_hit_o     = (wmark_i != '0) &&
                       (((fill_q.level <= wmark_i) && (fill_d.level > wmark_i)) || final_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= fill_d;
    end

    assign fill_o = fill_q.level;
    assign free_o = FILL_W'(DEPTH) - fill_q.level;

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (fill_q.level < FILL_W'(DEPTH)));

    assert_pop_empty_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q.level == '0 && pop_i && !push_i) |=> (fill_q.level == '0));

endmodule

// File: rtl/ixr_burst_seq.sv
module ixr_burst_seq
    import ixr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned FILL_W    = 7,
    parameter int unsigned MAX_BURST = 16,
    parameter int unsigned BURST_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_valid_i,
    input  logic [ADDR_W-1:0]  act_addr_i,
    input  logic [LEN_W-1:0]   act_len_i,
    input  logic               cancel_i,
    input  logic [FILL_W-1:0]  free_i,
    input  logic               eng_gnt_i,
    input  logic               eng_vld_i,
    output logic               eng_req_o,
    output logic [ADDR_W-1:0]  eng_addr_o,
    output logic [BURST_W-1:0] eng_len_o,
    output logic               push_o,
    output logic               last_o,
    output logic               draining_o
);

    typedef struct packed {
        sq_state_e          st;
        logic               loaded;
        logic [ADDR_W-1:0]  cur;
        logic [LEN_W-1:0]   remain;
        logic [BURST_W-1:0] left;
        logic [BURST_W-1:0] req_len;
    } seq_t;

    seq_t               seq_d, seq_q;
    logic [BURST_W-1:0] plan_len;
    logic [BURST_W-1:0] drop_left;

    always_comb begin
        seq_d     = seq_q;
        push_o    = 1'b0;
        last_o    = 1'b0;
        plan_len  = BURST_W'(min3(MAX_BURST, 32'(seq_q.remain), 32'(free_i)));
        drop_left = seq_q.left - BURST_W'(eng_vld_i);
        case (seq_q.st)
            SQ_IDLE: begin
                if (cancel_i) begin
                    seq_d.loaded = 1'b0;
                end else if (!seq_q.loaded) begin
                    if (act_valid_i) begin
                        seq_d.loaded = 1'b1;
                        seq_d.cur    = act_addr_i;
                        seq_d.remain = act_len_i;
                    end
                end else if (free_i != '0) begin
                    seq_d.st      = SQ_REQ;
                    seq_d.req_len = plan_len;
                end
            end
            SQ_REQ: begin
                if (cancel_i) begin
                    seq_d.st     = SQ_IDLE;
                    seq_d.loaded = 1'b0;
                end else if (eng_gnt_i) begin
                    seq_d.st   = SQ_DATA;
                    seq_d.left = seq_q.req_len;
                end
            end
            SQ_DATA: begin
                if (cancel_i) begin
                    seq_d.loaded = 1'b0;
                    seq_d.left   = drop_left;
                    seq_d.st     = (drop_left == '0) ? SQ_IDLE : SQ_DRAIN;
                end else if (eng_vld_i) begin
                    push_o       = 1'b1;
                    seq_d.cur    = seq_q.cur + ADDR_W'(1);
                    seq_d.remain = seq_q.remain - LEN_W'(1);
                    seq_d.left   = seq_q.left - BURST_W'(1);
                    if (seq_q.left == BURST_W'(1)) seq_d.st = SQ_IDLE;
                    if (seq_q.remain == LEN_W'(1)) begin
                        last_o       = 1'b1;
                        seq_d.loaded = 1'b0;
                    end
                end
            end
            SQ_DRAIN: begin
                if (eng_vld_i) begin
                    seq_d.left = seq_q.left - BURST_W'(1);
                    if (seq_q.left == BURST_W'(1)) seq_d.st = SQ_IDLE;
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= SQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign eng_req_o  = (seq_q.st == SQ_REQ);
    assign eng_addr_o = seq_q.cur;
    assign eng_len_o  = seq_q.req_len;
    assign draining_o = (seq_q.st == SQ_DRAIN);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && !eng_gnt_i && !cancel_i) |=>
            (eng_req_o && $stable(eng_addr_o) && $stable(eng_len_o)));

    assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_o |-> ((eng_len_o != '0) && (32'(eng_len_o) <= MAX_BURST) &&
                       (32'(eng_len_o) <= 32'(free_i))));

    assert_burst_within_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_DATA) |-> (32'(seq_q.left) <= 32'(seq_q.remain)));

    assert_drain_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        draining_o |-> !push_o);

endmodule

// File: rtl/ixr_read_sequencer.sv
module ixr_read_sequencer
    import ixr_pkg::*;
#(
    parameter  int unsigned ADDR_W    = 32,
    parameter  int unsigned LEN_W     = 16,
    parameter  int unsigned DEPTH     = 64,
    parameter  int unsigned MAX_BURST = 16,
    localparam int unsigned FILL_W    = $clog2(DEPTH + 1),
    localparam int unsigned BURST_W   = $clog2(MAX_BURST + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_start_i,
    input  logic               sw_cancel_i,
    input  logic [ADDR_W-1:0]  sw_addr_i,
    input  logic [LEN_W-1:0]   sw_len_i,
    input  logic [FILL_W-1:0]  sw_wmark_i,
    input  logic [2:0]         irq_clr_i,
    output logic               busy_o,
    output logic [FILL_W-1:0]  fill_level_o,
    output logic               irq_wmark_o,
    output logic               irq_done_o,
    output logic               irq_reject_o,
    output logic               eng_req_o,
    output logic [ADDR_W-1:0]  eng_addr_o,
    output logic [BURST_W-1:0] eng_len_o,
    input  logic               eng_gnt_i,
    input  logic               eng_vld_i,
    input  logic [7:0]         eng_data_i,
    output logic               buf_push_o,
    output logic [7:0]         buf_data_o,
    input  logic               buf_pop_i
);

    logic              act_valid, q_full, q_reject;
    logic [ADDR_W-1:0] act_addr;
    logic [LEN_W-1:0]  act_len;
    logic [FILL_W-1:0] free_cnt;
    logic              push, last, draining, wm_hit;

    ixr_op_queue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (sw_start_i),
        .cancel_i   (sw_cancel_i),
        .retire_i   (last),
        .addr_i     (sw_addr_i),
        .len_i      (sw_len_i),
        .act_valid_o(act_valid),
        .act_addr_o (act_addr),
        .act_len_o  (act_len),
        .full_o     (q_full),
        .reject_o   (q_reject)
    );

    ixr_burst_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FILL_W(FILL_W),
        .MAX_BURST(MAX_BURST), .BURST_W(BURST_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_valid_i(act_valid),
        .act_addr_i (act_addr),
        .act_len_i  (act_len),
        .cancel_i   (sw_cancel_i),
        .free_i     (free_cnt),
        .eng_gnt_i  (eng_gnt_i),
        .eng_vld_i  (eng_vld_i),
        .eng_req_o  (eng_req_o),
        .eng_addr_o (eng_addr_o),
        .eng_len_o  (eng_len_o),
        .push_o     (push),
        .last_o     (last),
        .draining_o (draining)
    );

    ixr_fill_track #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (buf_pop_i),
        .final_i (last),
        .wmark_i (sw_wmark_i),
        .fill_o  (fill_level_o),
        .free_o  (free_cnt),
        .wm_hit_o(wm_hit)
    );

    typedef struct packed {
        logic [IRQ_N-1:0] flag;
    } irq_t;

    irq_t       irq_d, irq_q;
    logic [IRQ_N-1:0] irq_set;

    always_comb begin
        irq_set             = '0;
        irq_set[IRQ_WMARK]  = wm_hit;
        irq_set[IRQ_DONE]   = last;
        irq_set[IRQ_REJECT] = q_reject;
        irq_d.flag          = irq_set | (irq_q.flag & ~irq_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_wmark_o  = irq_q.flag[IRQ_WMARK];
    assign irq_done_o   = irq_q.flag[IRQ_DONE];
    assign irq_reject_o = irq_q.flag[IRQ_REJECT];
    assign busy_o       = act_valid || draining;
    assign buf_push_o   = push;
    assign buf_data_o   = eng_data_i;

    assert_reject_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_start_i && !sw_cancel_i && q_full) |=> irq_reject_o);

    assert_done_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> irq_done_o);

    assert_cancel_drops_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cancel_i |=> !eng_req_o);

    assert_cancel_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_cancel_i && !irq_done_o) |=> !irq_done_o);

    assert_clear_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i[IRQ_DONE] && !last) |=> !irq_done_o);

    assert_push_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        buf_push_o |-> busy_o);

endmodule

// File: tb/ixr_read_sequencer_test.sv
module ixr_read_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int DEPTH = 16;
    localparam int MAXB = 8;
    localparam int FW = $clog2(DEPTH + 1);
    localparam int BW = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_start_i = 1'b0, sw_cancel_i = 1'b0;
    logic [AW-1:0] sw_addr_i = '0;
    logic [LW-1:0] sw_len_i = '0;
    logic [FW-1:0] sw_wmark_i = '0;
    logic [2:0] irq_clr_i = '0;
    logic busy_o, irq_wmark_o, irq_done_o, irq_reject_o, eng_req_o;
    logic [FW-1:0] fill_level_o;
    logic [AW-1:0] eng_addr_o;
    logic [BW-1:0] eng_len_o;
    logic eng_gnt_i = 1'b0, eng_vld_i = 1'b0, buf_pop_i = 1'b0;
    logic [7:0] eng_data_i = '0;
    logic buf_push_o;
    logic [7:0] buf_data_o;

    ixr_read_sequencer #(.ADDR_W(AW), .LEN_W(LW), .DEPTH(DEPTH), .MAX_BURST(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .sw_start_i(sw_start_i), .sw_cancel_i(sw_cancel_i),
        .sw_addr_i(sw_addr_i), .sw_len_i(sw_len_i), .sw_wmark_i(sw_wmark_i),
        .irq_clr_i(irq_clr_i), .busy_o(busy_o), .fill_level_o(fill_level_o),
        .irq_wmark_o(irq_wmark_o), .irq_done_o(irq_done_o), .irq_reject_o(irq_reject_o),
        .eng_req_o(eng_req_o), .eng_addr_o(eng_addr_o), .eng_len_o(eng_len_o),
        .eng_gnt_i(eng_gnt_i), .eng_vld_i(eng_vld_i), .eng_data_i(eng_data_i),
        .buf_push_o(buf_push_o), .buf_data_o(buf_data_o), .buf_pop_i(buf_pop_i)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0, n_fail = 0;

    // reference model state
    int  m_fill = 0, m_fill_prev = 0, m_drain = 0;
    bit  m_wm = 0, m_done = 0, m_rej = 0;
    int  m_len[$];
    int  m_addr[$];

    // engine and master stand-ins
    int  e_left = 0, e_addr = 0, lat_len = 0, lat_addr = 0, req_wait = 0, cyc = 0;
    bit  d_vld = 0, d_gnt = 0, req_prev = 0;
    int  gnt_lat = 0, pop_period = 1;
    bit  gaps = 0, pop_en = 0, pop_force = 0;
    int  req_hold_addr = 0, req_hold_len = 0;

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // cycle loop: compare, drive stand-ins, predict the next edge
    initial begin
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            cyc++;
            check(32'(fill_level_o) == m_fill, "R6", "fill level", 32'(fill_level_o), m_fill);
            check(busy_o == ((m_len.size() > 0) || (m_drain > 0)), "R12", "busy",
                  32'(busy_o), 32'((m_len.size() > 0) || (m_drain > 0)));
            check(irq_wmark_o == m_wm, "R7 R8", "watermark flag", 32'(irq_wmark_o), 32'(m_wm));
            check(irq_done_o == m_done, "R9", "done flag", 32'(irq_done_o), 32'(m_done));
            check(irq_reject_o == m_rej, "R3", "reject flag", 32'(irq_reject_o), 32'(m_rej));
            if (eng_req_o && !req_prev) begin
                if (m_len.size() == 0) begin
                    check(1'b0, "R10", "request with nothing queued", 1, 0);
                end else begin
                    check(32'(eng_len_o) == mn(MAXB, mn(m_len[0], DEPTH - m_fill_prev)),
                          "R4", "burst length", 32'(eng_len_o),
                          mn(MAXB, mn(m_len[0], DEPTH - m_fill_prev)));
                    check(32'(eng_addr_o) == m_addr[0], "R5", "burst address",
                          32'(eng_addr_o), m_addr[0]);
                end
                req_hold_addr = 32'(eng_addr_o);
                req_hold_len  = 32'(eng_len_o);
            end else if (eng_req_o && req_prev) begin
                check(32'(eng_addr_o) == req_hold_addr && 32'(eng_len_o) == req_hold_len,
                      "R4", "request held", 32'(eng_len_o), req_hold_len);
            end
            req_prev = eng_req_o;

            if (d_vld) begin e_left--; e_addr++; end
            if (d_gnt) begin e_left = lat_len; e_addr = lat_addr; end
            d_vld = 1'b0;
            d_gnt = 1'b0;
            if (e_left > 0) begin
                d_vld = !(gaps && (cyc % 4 == 1));
            end else if (eng_req_o) begin
                if (req_wait >= gnt_lat) begin
                    d_gnt = 1'b1; lat_len = 32'(eng_len_o); lat_addr = 32'(eng_addr_o);
                    req_wait = 0;
                end else begin
                    req_wait++;
                end
            end
            eng_vld_i  = d_vld;
            eng_gnt_i  = d_gnt;
            eng_data_i = pat(e_addr);
            buf_pop_i  = (pop_en && fill_level_o != '0 && (cyc % pop_period == 0)) || pop_force;

            #1;
            begin
                int  qcnt, newf;
                bit  fin, set_wm;
                qcnt = m_len.size();
                fin = 1'b0;
                m_fill_prev = m_fill;
                if (sw_cancel_i) begin
                    m_len.delete();
                    m_addr.delete();
                    m_drain = e_left - (d_vld ? 1 : 0);
                end else if (m_drain > 0 && d_vld) begin
                    m_drain--;
                end
                if (buf_push_o) begin
                    if (m_len.size() == 0) begin
                        check(1'b0, "R10", "push with no live operation", 1, 0);
                    end else begin
                        check(buf_data_o == pat(m_addr[0]), "R2", "pushed byte order",
                              32'(buf_data_o), 32'(pat(m_addr[0])));
                        m_addr[0]++;
                        m_len[0]--;
                        if (m_len[0] == 0) begin
                            fin = 1'b1;
                            void'(m_len.pop_front());
                            void'(m_addr.pop_front());
                        end
                    end
                end
                newf = m_fill + (buf_push_o ? 1 : 0) - ((buf_pop_i && m_fill > 0) ? 1 : 0);
                set_wm = (sw_wmark_i != '0) &&
                         ((m_fill <= 32'(sw_wmark_i) && newf > 32'(sw_wmark_i)) || fin);
                m_wm   = set_wm | (m_wm & !irq_clr_i[0]);
                m_done = fin | (m_done & !irq_clr_i[1]);
                m_rej  = (sw_start_i && !sw_cancel_i && qcnt == 2) | (m_rej & !irq_clr_i[2]);
                if (sw_start_i && !sw_cancel_i && qcnt < 2) begin
                    m_len.push_back(32'(sw_len_i));
                    m_addr.push_back(32'(sw_addr_i));
                end
                m_fill = newf;
            end
        end
    end

    task automatic sw_start(input int addr, input int len);
        @(negedge clk);
        sw_addr_i = AW'(addr); sw_len_i = LW'(len); sw_start_i = 1'b1;
        @(negedge clk);
        sw_start_i = 1'b0;
    endtask

    task automatic sw_clear(input logic [2:0] mask);
        @(negedge clk);
        irq_clr_i = mask;
        @(negedge clk);
        irq_clr_i = '0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic drain_buffer();
        pop_en = 1'b1; pop_period = 1;
        while (fill_level_o != '0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy_o && fill_level_o == '0 && !eng_req_o, "R1", "idle after reset",
              32'(busy_o), 0);
        check(!irq_wmark_o && !irq_done_o && !irq_reject_o, "R1", "flags after reset",
              32'({irq_wmark_o, irq_done_o, irq_reject_o}), 0);

        // R2, R9: single short transfer, watermark disabled (R7)
        pop_en = 1'b1; pop_period = 1; sw_wmark_i = '0;
        sw_start(32'h100, 5);
        wait_idle();
        check(irq_done_o, "R9", "done after short transfer", 32'(irq_done_o), 1);
        check(!irq_wmark_o, "R7", "zero watermark keeps flag low", 32'(irq_wmark_o), 0);
        sw_clear(3'b111);
        @(negedge clk);
        check(!irq_done_o, "R11", "done cleared by write 1", 32'(irq_done_o), 0);

        // R4, R5, R7: long transfer stalls on a full buffer, then resumes
        pop_en = 1'b0; sw_wmark_i = FW'(10); gnt_lat = 2;
        sw_start(32'h2000, 40);
        repeat (80) @(negedge clk);
        check(32'(fill_level_o) == DEPTH, "R4", "buffer filled to depth", 32'(fill_level_o), DEPTH);
        check(!eng_req_o && busy_o, "R4", "no request while full", 32'(eng_req_o), 0);
        check(irq_wmark_o, "R7", "watermark crossing", 32'(irq_wmark_o), 1);
        sw_clear(3'b001);
        pop_en = 1'b1; pop_period = 3;
        wait_idle();
        check(irq_done_o, "R5", "resumed transfer completed", 32'(irq_done_o), 1);
        drain_buffer();
        sw_clear(3'b111);

        // R8: final byte raises watermark although fill stays below it
        pop_en = 1'b0; sw_wmark_i = FW'(12); gnt_lat = 0;
        sw_start(32'h3000, 6);
        wait_idle();
        check(32'(fill_level_o) == 6, "R8", "fill below watermark", 32'(fill_level_o), 6);
        check(irq_wmark_o, "R8", "watermark from final byte", 32'(irq_wmark_o), 1);
        drain_buffer();
        sw_clear(3'b111);

        // R6: pops at zero fill are ignored
        pop_en = 1'b0;
        @(negedge clk);
        pop_force = 1'b1;
        repeat (3) @(negedge clk);
        pop_force = 1'b0;
        @(negedge clk);
        check(fill_level_o == '0, "R6", "pop at empty ignored", 32'(fill_level_o), 0);

        // R2, R3: two queued operations, third start refused
        pop_en = 1'b1; pop_period = 2; gaps = 1'b1; gnt_lat = 3; sw_wmark_i = '0;
        sw_start(32'h5000, 20);
        sw_start(32'h6000, 10);
        sw_start(32'h7000, 4);
        @(negedge clk);
        check(irq_reject_o, "R3", "third start refused", 32'(irq_reject_o), 1);
        wait_idle();
        check(irq_done_o, "R2", "queued operation finished", 32'(irq_done_o), 1);
        drain_buffer();
        sw_clear(3'b111);

        // R10: cancel while a burst is in flight
        pop_en = 1'b1; pop_period = 2; gnt_lat = 1;
        sw_start(32'h8000, 30);
        @(negedge clk);
        while (!(e_left > 2)) @(negedge clk);
        sw_cancel_i = 1'b1;
        @(negedge clk);
        sw_cancel_i = 1'b0;
        check(!eng_req_o, "R10", "request withdrawn", 32'(eng_req_o), 0);
        wait_idle();
        check(!irq_done_o, "R10", "no done after cancel", 32'(irq_done_o), 0);
        check(!busy_o, "R12", "idle after drain", 32'(busy_o), 0);
        drain_buffer();
        sw_start(32'h9000, 9);
        wait_idle();
        check(irq_done_o, "R10", "new operation after cancel", 32'(irq_done_o), 1);
        drain_buffer();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule